// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block lays a small 32x32 pointer image over a stream of palette-indexed pixels on their way to scan-out. Software loads two planes of 32 row words each, a transparency plane and a colour-select plane, plus a position word, through a simple 32-bit register port. Each row word describes one cursor row, and its most significant bit is the leftmost pixel of that row.

For every pixel that arrives with its screen coordinates and an 8-bit palette index, the block decides whether the pixel lies under an opaque cursor cell. An opaque cell is replaced by one of two overlay colour indices, 258 or 259, and all other pixels pass through unchanged as 9-bit indices. The result appears one clock after the pixel. The cursor is clipped at the right screen edge, and it vanishes entirely when its X position is at or past the screen width. A spare general-purpose register with one forced status bit sits on the same port.

Top module: `hwcur_overlay`

## Requirements
- R1: After reset, out_valid is 0, both cursor coordinates are 0xF000 (off screen), and every row word of both planes is 0, so no pixel is altered.
- R2: A write at byte offset 0x8FC sets cursor X from write data bits 31:16 and cursor Y from bits 15:0.
- R3: A write at offset 0x900 + 4*r (r = 0..31) loads transparency row r; a write at offset 0x980 + 4*r loads colour-select row r.
- R4: A pixel (x, y) is covered exactly when X <= x < X+32 and Y <= y < Y+32; the cell used is row y-Y, bit 31-(x-X) of that row's word.
- R5: A pixel that is not covered, or is covered with its transparency bit 0, leaves as {1'b0, pix_idx}.
- R6: A covered pixel with transparency bit 1 leaves as index 259 when its colour-select bit is 1 and as index 258 when it is 0.
- R7: When X is at or beyond the screen width (1024 by default) nothing is drawn, and pixels with x at or beyond the screen width are never altered (right-edge clip).
- R8: A write at offset 0x818 stores the data in the spare register; a read there returns the stored value ORed with 0x02000000; a read at any other offset returns 0. Read data appears in the cycle after reg_rd and holds until the next read.
- R9: out_valid is pix_valid delayed by exactly one clock, and out_idx is the decision for the pixel presented in that earlier cycle, for back-to-back pixels as well.
- R10: Writes to offsets outside the decoded ones change neither the cursor position nor any row word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel row |
| pix_idx | input | 8 | Input pixel palette index |
| out_valid | output | 1 | Output pixel valid |
| out_idx | output | 9 | Output palette index: pass-through, 258 or 259 |

## Verification
Directed pixels sit on the four corners of the 32x32 square and one step outside each edge, which separates an off-by-one in the row or column window from a reversed bit order inside a row word. Planes with only the end bits set, alternating colour-select patterns and fully opaque rows tell a swapped plane or a swapped 258/259 choice apart from correct behaviour. Cursor positions just left of the screen edge and at or past it exercise clipping and the off-screen rule. Random planes, positions and pixel streams around the cursor, issued back to back, compare every output against a bench model and expose latency slips as well as decode errors.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;

   // Decision taken for one pixel.
   typedef enum logic [1:0] {
      SEL_PASS    = 2'd0,
      SEL_COLOR_A = 2'd1,
      SEL_COLOR_B = 2'd2
   } ovl_sel_e;

   // First overlay palette slot; the second one follows it directly.
   localparam int unsigned OVL_BASE = 258;

endpackage

// File: rtl/hwcur_regfile.sv
module hwcur_regfile #(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int COORD_W   = 16,
   parameter int CUR_SIZE  = 32,
   parameter int POS_OFS   = 'h8FC,
   parameter int MISC_OFS  = 'h818,
   parameter int MASK_BASE = 'h900,
   parameter int BITS_BASE = 'h980,
   parameter logic [COORD_W-1:0] POS_RESET  = COORD_W'('hF000),
   parameter logic [DATA_W-1:0]  MISC_FORCE = DATA_W'('h0200_0000)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic                               rd_en,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [DATA_W-1:0]                  wdata,
   output logic [DATA_W-1:0]                  rdata,
   output logic [COORD_W-1:0]                 cur_x,
   output logic [COORD_W-1:0]                 cur_y,
   output logic [CUR_SIZE-1:0][DATA_W-1:0]    mask_rows,
   output logic [CUR_SIZE-1:0][DATA_W-1:0]    bits_rows
);

   localparam int ROW_W = $clog2(CUR_SIZE);
   localparam int SPAN  = 4 * CUR_SIZE;
   localparam logic [ADDR_W-1:0] POS_A   = ADDR_W'(POS_OFS);
   localparam logic [ADDR_W-1:0] MISC_A  = ADDR_W'(MISC_OFS);
   localparam logic [ADDR_W-1:0] MASK_LO = ADDR_W'(MASK_BASE);
   localparam logic [ADDR_W-1:0] MASK_HI = ADDR_W'(MASK_BASE + SPAN);
   localparam logic [ADDR_W-1:0] BITS_LO = ADDR_W'(BITS_BASE);
   localparam logic [ADDR_W-1:0] BITS_HI = ADDR_W'(BITS_BASE + SPAN);

   if (2 * COORD_W > DATA_W) begin : g_bad_coord
      $error("hwcur_regfile: position word cannot hold two coordinates");
   end
   if (MASK_BASE + SPAN > (1 << ADDR_W) || BITS_BASE + SPAN > (1 << ADDR_W)) begin : g_bad_span
      $error("hwcur_regfile: plane window exceeds the address space");
   end

   logic             hit_pos;
   logic             hit_misc;
   logic             hit_mask;
   logic             hit_bits;
   logic [ROW_W-1:0] mask_row;
   logic [ROW_W-1:0] bits_row;
   logic [DATA_W-1:0] misc_q;

   assign hit_pos  = (addr == POS_A);
   assign hit_misc = (addr == MISC_A);
   assign hit_mask = (addr >= MASK_LO) && (addr < MASK_HI);
   assign hit_bits = (addr >= BITS_LO) && (addr < BITS_HI);
   assign mask_row = ROW_W'((addr - MASK_LO) >> 2);
   assign bits_row = ROW_W'((addr - BITS_LO) >> 2);

   // Position and spare register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_x  <= POS_RESET;
         cur_y  <= POS_RESET;
         misc_q <= '0;
      end else if (wr_en) begin
         if (hit_pos) begin
            cur_x <= wdata[2*COORD_W-1:COORD_W];
            cur_y <= wdata[COORD_W-1:0];
         end
         if (hit_misc) begin
            misc_q <= wdata;
         end
      end
   end

   // One storage word per plane row.
   for (genvar r = 0; r < CUR_SIZE; r++) begin : g_row
      logic [DATA_W-1:0] mask_q;
      logic [DATA_W-1:0] bits_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q <= '0;
            bits_q <= '0;
         end else if (wr_en) begin
            if (hit_mask && (mask_row == ROW_W'(r))) begin
               mask_q <= wdata;
            end
            if (hit_bits && (bits_row == ROW_W'(r))) begin
               bits_q <= wdata;
            end
         end
      end
      assign mask_rows[r] = mask_q;
      assign bits_rows[r] = bits_q;
   end

   // Registered read port.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= hit_misc ? (misc_q | MISC_FORCE) : '0;
      end
   end

endmodule

// File: rtl/hwcur_hit.sv
module hwcur_hit #(
   parameter int COORD_W  = 16,
   parameter int DATA_W   = 32,
   parameter int CUR_SIZE = 32,
   parameter int SCREEN_W = 1024
) (
   input  logic [COORD_W-1:0]          pix_x,
   input  logic [COORD_W-1:0]          pix_y,
   input  logic [COORD_W-1:0]          cur_x,
   input  logic [COORD_W-1:0]          cur_y,
   output logic                        covered,
   output logic [$clog2(CUR_SIZE)-1:0] row,
   output logic [$clog2(DATA_W)-1:0]   bit_pos
);

   localparam int ROW_W  = $clog2(CUR_SIZE);
   localparam int BIT_W  = $clog2(DATA_W);
   localparam int EXT    = COORD_W + 1;
   localparam int SW_LOG = $clog2(SCREEN_W);

   if (CUR_SIZE > DATA_W || (1 << ROW_W) != CUR_SIZE) begin : g_bad_size
      $error("hwcur_hit: cursor size must be a power of two no wider than a word");
   end
   if (SCREEN_W >= (1 << COORD_W) || SCREEN_W < 1) begin : g_bad_screen
      $error("hwcur_hit: screen width does not fit the coordinate width");
   end

   logic [EXT-1:0] dx;
   logic [EXT-1:0] dy;
   logic           in_x;
   logic           in_y;
   logic           cur_on;
   logic           pix_on;

   // Difference with a borrow bit: top bit set means pixel lies before cursor.
   assign dx   = {1'b0, pix_x} - {1'b0, cur_x};
   assign dy   = {1'b0, pix_y} - {1'b0, cur_y};
   assign in_x = !dx[EXT-1] && (dx < EXT'(CUR_SIZE));
   assign in_y = !dy[EXT-1] && (dy < EXT'(CUR_SIZE));

   // Screen-edge test: a power-of-two width needs only a zero check of high bits.
   if ((SCREEN_W & (SCREEN_W - 1)) == 0) begin : g_edge_pow2
      assign cur_on = ~|cur_x[COORD_W-1:SW_LOG];
      assign pix_on = ~|pix_x[COORD_W-1:SW_LOG];
   end else begin : g_edge_cmp
      assign cur_on = cur_x < COORD_W'(SCREEN_W);
      assign pix_on = pix_x < COORD_W'(SCREEN_W);
   end

   assign covered = in_x && in_y && cur_on && pix_on;
   assign row     = dy[ROW_W-1:0];
   // Leftmost cursor pixel maps to the most significant bit of the word.
   assign bit_pos = BIT_W'(DATA_W - 1) - BIT_W'(dx[ROW_W-1:0]);

endmodule

// File: rtl/hwcur_merge.sv
module hwcur_merge
   import hwcur_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CUR_SIZE = 32,
   parameter int IDX_W    = 8,
   parameter int OUT_W    = 9
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_valid,
   input  logic [IDX_W-1:0]                  in_idx,
   input  logic                              covered,
   input  logic [$clog2(CUR_SIZE)-1:0]       row,
   input  logic [$clog2(DATA_W)-1:0]         bit_pos,
   input  logic [CUR_SIZE-1:0][DATA_W-1:0]   mask_rows,
   input  logic [CUR_SIZE-1:0][DATA_W-1:0]   bits_rows,
   output logic                              out_valid,
   output logic [OUT_W-1:0]                  out_idx
);

   if (OUT_W <= IDX_W || (1 << OUT_W) <= int'(OVL_BASE) + 1) begin : g_bad_out
      $error("hwcur_merge: output index too narrow for overlay slots");
   end

   logic [DATA_W-1:0] mask_word;
   logic [DATA_W-1:0] bits_word;
   logic              mask_bit;
   logic              bits_bit;
   ovl_sel_e          sel;
   logic [OUT_W-1:0]  nxt_idx;

   assign mask_word = mask_rows[row];
   assign bits_word = bits_rows[row];
   assign mask_bit  = mask_word[bit_pos];
   assign bits_bit  = bits_word[bit_pos];

   always_comb begin
      sel = SEL_PASS;
      if (covered && mask_bit) begin
         sel = bits_bit ? SEL_COLOR_B : SEL_COLOR_A;
      end
   end

   always_comb begin
      case (sel)
         SEL_COLOR_A: nxt_idx = OUT_W'(OVL_BASE);
         SEL_COLOR_B: nxt_idx = OUT_W'(OVL_BASE + 1);
         default:     nxt_idx = {{(OUT_W - IDX_W){1'b0}}, in_idx};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_idx   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_idx <= nxt_idx;
         end
      end
   end

endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int COORD_W  = 16,
   parameter int IDX_W    = 8,
   parameter int OUT_W    = 9,
   parameter int CUR_SIZE = 32,
   parameter int SCREEN_W = 1024
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               pix_valid,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [IDX_W-1:0]   pix_idx,
   output logic               out_valid,
   output logic [OUT_W-1:0]   out_idx
);

   localparam int ROW_W = $clog2(CUR_SIZE);
   localparam int BIT_W = $clog2(DATA_W);

   logic [COORD_W-1:0]              cur_x;
   logic [COORD_W-1:0]              cur_y;
   logic [CUR_SIZE-1:0][DATA_W-1:0] mask_rows;
   logic [CUR_SIZE-1:0][DATA_W-1:0] bits_rows;
   logic                            covered;
   logic [ROW_W-1:0]                row;
   logic [BIT_W-1:0]                bit_pos;

   hwcur_regfile #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .COORD_W  (COORD_W),
      .CUR_SIZE (CUR_SIZE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .rd_en     (reg_rd),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .cur_x     (cur_x),
      .cur_y     (cur_y),
      .mask_rows (mask_rows),
      .bits_rows (bits_rows)
   );

   hwcur_hit #(
      .COORD_W  (COORD_W),
      .DATA_W   (DATA_W),
      .CUR_SIZE (CUR_SIZE),
      .SCREEN_W (SCREEN_W)
   ) u_hit (
      .pix_x   (pix_x),
      .pix_y   (pix_y),
      .cur_x   (cur_x),
      .cur_y   (cur_y),
      .covered (covered),
      .row     (row),
      .bit_pos (bit_pos)
   );

   hwcur_merge #(
      .DATA_W   (DATA_W),
      .CUR_SIZE (CUR_SIZE),
      .IDX_W    (IDX_W),
      .OUT_W    (OUT_W)
   ) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (pix_valid),
      .in_idx    (pix_idx),
      .covered   (covered),
      .row       (row),
      .bit_pos   (bit_pos),
      .mask_rows (mask_rows),
      .bits_rows (bits_rows),
      .out_valid (out_valid),
      .out_idx   (out_idx)
   );

endmodule

// File: rtl/hwcur_overlay_chk.sv
module hwcur_overlay_chk #(
   parameter int DATA_W   = 32,
   parameter int COORD_W  = 16,
   parameter int IDX_W    = 8,
   parameter int OUT_W    = 9,
   parameter int CUR_SIZE = 32,
   parameter int SCREEN_W = 1024
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_rd,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic               pix_valid,
   input logic [COORD_W-1:0] pix_y,
   input logic [IDX_W-1:0]   pix_idx,
   input logic               out_valid,
   input logic [OUT_W-1:0]   out_idx,
   input logic [COORD_W-1:0] cur_x,
   input logic [COORD_W-1:0] cur_y
);

   localparam logic [DATA_W-1:0] FORCE = DATA_W'('h0200_0000);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid); // R9
   AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !out_valid); // R9
   AST_OVL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_idx[OUT_W-1]) |-> (out_idx[OUT_W-2:1] == 1)); // R6
   AST_OFFSCREEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && (cur_x >= COORD_W'(SCREEN_W)))
      |=> (out_idx == {{(OUT_W-IDX_W){1'b0}}, $past(pix_idx)})); // R7
   AST_ABOVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && (pix_y < cur_y)) |=> !out_idx[OUT_W-1]); // R4
   AST_BELOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && ({1'b0, pix_y} >= ({1'b0, cur_y} + (COORD_W+1)'(CUR_SIZE))))
      |=> !out_idx[OUT_W-1]); // R4
   AST_RD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> ((reg_rdata == '0) || ((reg_rdata & FORCE) == FORCE))); // R8
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata)); // R8

endmodule

bind hwcur_overlay hwcur_overlay_chk #(
   .DATA_W   (DATA_W),
   .COORD_W  (COORD_W),
   .IDX_W    (IDX_W),
   .OUT_W    (OUT_W),
   .CUR_SIZE (CUR_SIZE),
   .SCREEN_W (SCREEN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_rd    (reg_rd),
   .reg_rdata (reg_rdata),
   .pix_valid (pix_valid),
   .pix_y     (pix_y),
   .pix_idx   (pix_idx),
   .out_valid (out_valid),
   .out_idx   (out_idx),
   .cur_x     (cur_x),
   .cur_y     (cur_y)
);

// File: tb/hwcur_overlay_test.sv
`timescale 1ns/1ps
module hwcur_overlay_test;

   localparam int SW = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pix_valid = 1'b0;
   logic [15:0] pix_x = '0;
   logic [15:0] pix_y = '0;
   logic [7:0]  pix_idx = '0;
   logic        out_valid;
   logic [8:0]  out_idx;

   always #2.5 clk = ~clk;

   hwcur_overlay uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pix_valid (pix_valid),
      .pix_x     (pix_x),
      .pix_y     (pix_y),
      .pix_idx   (pix_idx),
      .out_valid (out_valid),
      .out_idx   (out_idx)
   );

   int n_chk = 0;
   int n_bad = 0;

   // Bench model of the register state.
   logic [31:0] m_mask [32];
   logic [31:0] m_bits [32];
   int          m_cx = 'hF000;
   int          m_cy = 'hF000;
   logic [31:0] m_misc = '0;

   bit          pend = 1'b0;
   logic [8:0]  pend_exp = '0;
   string       pend_tag = "";

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] ref_px(int x, int y, int idx);
      int r;
      int c;
      if (m_cx < SW && x < SW && x >= m_cx && x < m_cx + 32 && y >= m_cy && y < m_cy + 32) begin
         r = y - m_cy;
         c = x - m_cx;
         if (m_mask[r][31 - c]) return m_bits[r][31 - c] ? 9'd259 : 9'd258;
      end
      return 9'(idx);
   endfunction

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = 12'(a);
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == 'h8FC) begin
         m_cx = int'(d[31:16]);
         m_cy = int'(d[15:0]);
      end else if (a >= 'h900 && a < 'h980) m_mask[(a - 'h900) >> 2] = d;
      else if (a >= 'h980 && a < 'hA00) m_bits[(a - 'h980) >> 2] = d;
      else if (a == 'h818) m_misc = d;
   endtask

   task automatic rd(int a, logic [31:0] exp, string req);
      @(negedge clk);
      reg_rd = 1'b1;
      reg_addr = 12'(a);
      @(negedge clk);
      reg_rd = 1'b0;
      check(req, reg_rdata, exp);
      @(negedge clk);
      check({req, " hold"}, reg_rdata, exp);
   endtask

   // Issue one pixel; the output for the previous one is checked first.
   task automatic px(int x, int y, int idx, string req);
      @(negedge clk);
      if (pend) begin
         check({pend_tag, " R9 valid"}, 32'(out_valid), 32'd1);
         check(pend_tag, 32'(out_idx), 32'(pend_exp));
      end
      pix_valid = 1'b1;
      pix_x = 16'(x);
      pix_y = 16'(y);
      pix_idx = 8'(idx);
      pend = 1'b1;
      pend_exp = ref_px(x, y, idx);
      pend_tag = req;
   endtask

   task automatic px_exp(int x, int y, int idx, int exp, string req);
      check({req, " model"}, 32'(ref_px(x, y, idx)), 32'(exp));
      px(x, y, idx, req);
   endtask

   task automatic flush();
      @(negedge clk);
      if (pend) begin
         check({pend_tag, " R9 valid"}, 32'(out_valid), 32'd1);
         check(pend_tag, 32'(out_idx), 32'(pend_exp));
      end
      pend = 1'b0;
      pix_valid = 1'b0;
      @(negedge clk);
      check("R9 idle", 32'(out_valid), 32'd0);
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      for (int i = 0; i < 32; i++) begin
         m_mask[i] = '0;
         m_bits[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 out_valid", 32'(out_valid), 32'd0);
      check("R1 rdata", reg_rdata, 32'd0);
      rd('h818, 32'h0200_0000, "R1 R8 misc after reset");
      px_exp(5, 5, 'h44, 'h44, "R1 pixel near origin");
      px_exp('hF005, 'hF005, 'h45, 'h45, "R1 pixel at reset position");
      flush();

      // R8: spare register and other reads
      wr('h818, 32'h00A5_005A);
      rd('h818, 32'h02A5_005A, "R8 misc read");
      rd('h900, 32'h0, "R8 read other offset");
      rd('h8FC, 32'h0, "R8 read position offset");

      // R2 R3 R4 R6: window edges and bit order
      wr('h8FC, 32'h0064_0032);          // X=100 Y=50
      wr('h900, 32'h8000_0001);          // row 0 mask
      wr('h980, 32'h8000_0000);          // row 0 bits
      wr('h97C, 32'hFFFF_FFFF);          // row 31 mask
      wr('h9FC, 32'h0000_FFFF);          // row 31 bits
      px_exp(100, 50, 7, 259, "R2 R6 top-left color B");
      px_exp(131, 50, 7, 258, "R3 R6 top-right color A");
      px_exp(101, 50, 9, 9, "R5 clear mask passes");
      px_exp(99, 50, 10, 10, "R4 left of window");
      px_exp(132, 50, 11, 11, "R4 right of window");
      px_exp(100, 81, 12, 258, "R4 bottom-left");
      px_exp(131, 81, 13, 259, "R4 bottom-right");
      px_exp(100, 82, 14, 14, "R4 below window");
      px_exp(100, 49, 15, 15, "R4 above window");
      flush();

      // R10: undecoded offsets change nothing
      wr('h8F8, 32'h0000_0000);
      wr('hA00, 32'h0000_0000);
      wr('h8FF, 32'h0000_0000);
      px_exp(100, 50, 16, 259, "R10 position and row kept");
      px_exp(131, 50, 17, 258, "R10 bits row kept");
      flush();

      // R7: clipping and off-screen
      wr('h900, 32'hFFFF_FFFF);
      wr('h980, 32'h0000_0000);
      wr('h8FC, {16'(SW - 4), 16'd0});
      px_exp(SW - 1, 0, 20, 258, "R7 last visible column");
      px_exp(SW, 0, 21, 21, "R7 clipped at right edge");
      wr('h8FC, {16'(SW), 16'd0});
      px_exp(SW, 0, 22, 22, "R7 cursor off screen");
      px_exp(SW + 3, 0, 23, 23, "R7 cursor off screen inside window");
      flush();

      // Random planes, positions and back-to-back streams (R3 R4 R5 R6 R9)
      for (int k = 0; k < 12; k++) begin
         int cx;
         int cy;
         for (int r = 0; r < 32; r++) begin
            wr('h900 + 4 * r, $urandom());
            wr('h980 + 4 * r, $urandom());
         end
         cx = int'($urandom_range(1060, 0));
         cy = int'($urandom_range(800, 0));
         wr('h8FC, {16'(cx), 16'(cy)});
         for (int p = 0; p < 200; p++) begin
            int x;
            int y;
            x = cx + int'($urandom_range(39, 0)) - 4;
            y = cy + int'($urandom_range(39, 0)) - 4;
            if (x < 0) x = 0;
            if (y < 0) y = 0;
            px(x, y, int'($urandom_range(255, 0)), "R4 R5 R6 R9 random");
         end
         flush();
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule